// File: doc/BRIEF.md
# Auto-Incrementing Display RAM Port

This block is the host-side access port of a monochrome display memory holding 64 lines of 128 bits. The host reaches the memory one byte at a time. It first loads a column pointer (X, which selects one of 16 byte positions in a line) and a line pointer (Y, one of 64 lines). Data reads and writes then act on the byte those pointers select.

A small step-control register decides whether X, Y, both or neither move forward after each data access. A block fill or a vertical strip therefore needs no further address commands. Column values beyond the last byte of a line are refused, and the pointer keeps its previous value.

The same block holds the storage. It also offers a second, line-wide read port to the scan logic, which fetches one full 128-bit line per request. A host write that hits the requested line in the same cycle is visible in that fetch.

Top module: `dram_host_port`

## Requirements
- R1: The memory holds LINES lines of LINE_BITS bits. Byte column c of a line occupies bits [8c+7:8c]. Driving `scan_line` with line L makes `scan_data` show all of line L one clock later.
- R2: `cmd_set_x` loads X from `host_din` when the value is below 16 (defaults). A value from 16 to 255 leaves X unchanged.
- R3: `cmd_set_y` loads Y from `host_din[5:0]`.
- R4: `cmd_set_ctl` loads the step controls: `host_din[0]` enables X stepping and `host_din[1]` enables Y stepping. After reset X = 0, Y = 0, and both steps are disabled.
- R5: Each `rd_stb` or `wr_stb` advances every enabled pointer by one after the access. Address commands and idle cycles never advance a pointer.
- R6: X steps from 15 to 0, and Y steps from 63 to 0.
- R7: A read strobe in cycle t puts the byte at the pointers of cycle t on `host_dout`, with `host_dout_vld` high, in cycle t+1. `host_dout_vld` is low in every other cycle. After reset it is low and `host_dout` is 0.
- R8: A write strobe stores `host_din` at the byte selected by the current X and Y. No other byte changes.
- R9: When a host write and a scan request target the same line in one cycle, the scan result already contains the new byte.
- R10: The host asserts at most one of the five strobes in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_set_x | input | 1 | Load column pointer from host_din |
| cmd_set_y | input | 1 | Load line pointer from host_din |
| cmd_set_ctl | input | 1 | Load step-control bits from host_din |
| rd_stb | input | 1 | Host data read |
| wr_stb | input | 1 | Host data write |
| host_din | input | 8 | Command value or write data |
| host_dout | output | 8 | Read data |
| host_dout_vld | output | 1 | Read data valid |
| scan_line | input | 6 | Line requested by scan logic |
| scan_data | output | 128 | Requested line, one cycle later |

## Verification
The memory is first filled line by line with X-only stepping. This checks that byte columns land at their bit positions and that X wraps inside a line. Directed runs then cover refused column values (16, 255), Y wrap at 63, reads with both steps off, and a write to the line being scanned in the same cycle. These separate the bypass from a stale read. A long seeded random mix follows: command values include refused columns, step modes change freely, and every cycle checks the scan port. Together they catch pointer steps on the wrong strobe type and read data captured after the step instead of before.

// File: rtl/dram_pkg.sv
package dram_pkg;
   localparam int unsigned HOST_W = 8;

   typedef struct packed {
      logic step_y;
      logic step_x;
   } step_ctl_t;
endpackage

// File: rtl/dram_addr_ctl.sv
module dram_addr_ctl
   import dram_pkg::*;
#(
   parameter int unsigned COLS  = 16,
   parameter int unsigned LINES = 64,
   localparam int unsigned XW = $clog2(COLS),
   localparam int unsigned YW = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_x,
   input  logic              set_y,
   input  logic              set_ctl,
   input  logic              access,
   input  logic [HOST_W-1:0] din,
   output logic [XW-1:0]     x_o,
   output logic [YW-1:0]     y_o
);
   localparam logic [HOST_W:0] X_LIMIT = (HOST_W+1)'(COLS);
   localparam logic [XW-1:0]   X_ONE   = XW'(1);
   localparam logic [YW-1:0]   Y_ONE   = YW'(1);

   generate
      if ((1 << XW) != COLS) begin : g_bad_cols
         $error("COLS must be a power of two");
      end
      if ((1 << YW) != LINES) begin : g_bad_lines
         $error("LINES must be a power of two");
      end
      if (COLS > (1 << HOST_W) || YW > HOST_W) begin : g_bad_fit
         $error("pointers must fit the host byte");
      end
   endgenerate

   logic [XW-1:0] x_q;
   logic [YW-1:0] y_q;
   step_ctl_t     ctl_q;
   logic          x_ok;

   assign x_ok = ({1'b0, din} < X_LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q   <= '0;
         y_q   <= '0;
         ctl_q <= '0;
      end else begin
         if (set_x && x_ok)  x_q <= din[XW-1:0];
         else if (access && ctl_q.step_x) x_q <= x_q + X_ONE;
         if (set_y)          y_q <= din[YW-1:0];
         else if (access && ctl_q.step_y) y_q <= y_q + Y_ONE;
         if (set_ctl)        ctl_q <= step_ctl_t'(din[1:0]);
      end
   end

   assign x_o = x_q;
   assign y_o = y_q;

   // R2: a refused column value keeps X
   a_r2_x_reject: assert property (@(posedge clk) disable iff (!rst_n)
      (set_x && !access && din >= HOST_W'(COLS)) |=> $stable(x_q));
   // R5: no access, no column command -> X holds
   a_r5_x_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!access && !set_x) |=> $stable(x_q));
   // R5: no access, no line command -> Y holds
   a_r5_y_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!access && !set_y) |=> $stable(y_q));
   // R6: last line wraps to line 0
   a_r6_y_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (access && !set_y && ctl_q.step_y && y_q == YW'(LINES-1)) |=> (y_q == '0));
   // R6: last column wraps to column 0
   a_r6_x_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (access && !set_x && ctl_q.step_x && x_q == XW'(COLS-1)) |=> (x_q == '0));
endmodule

// File: rtl/dram_store.sv
module dram_store
   import dram_pkg::*;
#(
   parameter int unsigned LINE_BITS = 128,
   parameter int unsigned LINES     = 64,
   localparam int unsigned COLS = LINE_BITS / HOST_W,
   localparam int unsigned XW   = $clog2(COLS),
   localparam int unsigned YW   = $clog2(LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic                 rd,
   input  logic [XW-1:0]        x,
   input  logic [YW-1:0]        y,
   input  logic [HOST_W-1:0]    din,
   input  logic [YW-1:0]        scan_line,
   output logic [HOST_W-1:0]    dout,
   output logic                 dout_vld,
   output logic [LINE_BITS-1:0] scan_data
);
   generate
      if (COLS * HOST_W != LINE_BITS) begin : g_bad_line
         $error("LINE_BITS must be a multiple of the host byte");
      end
   endgenerate

   logic [LINE_BITS-1:0] mem [LINES];
   logic [LINE_BITS-1:0] row;
   logic [LINE_BITS-1:0] merged;

   assign row = mem[y];

   for (genvar c = 0; c < COLS; c++) begin : g_col
      assign merged[c*HOST_W +: HOST_W] =
         (wr && x == XW'(c)) ? din : row[c*HOST_W +: HOST_W];
   end

   always_ff @(posedge clk) begin
      if (wr) mem[y] <= merged;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout      <= '0;
         dout_vld  <= 1'b0;
         scan_data <= '0;
      end else begin
         dout_vld <= rd;
         if (rd) dout <= row[x*HOST_W +: HOST_W];
         scan_data <= (wr && scan_line == y) ? merged : mem[scan_line];
      end
   end

   // R7: read strobe yields valid data next cycle
   a_r7_vld_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
      rd |=> dout_vld);
   // R7: no strobe, no valid
   a_r7_vld_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> !dout_vld);
   // R7: data holds when no read
   a_r7_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> $stable(dout));
   // R9: same-cycle write is visible in the scan result
   a_r9_scan_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && scan_line == y) |=> (scan_data[$past(x)*HOST_W +: HOST_W] == $past(din)));
endmodule

// File: rtl/dram_host_port.sv
module dram_host_port
   import dram_pkg::*;
#(
   parameter int unsigned LINE_BITS = 128,
   parameter int unsigned LINES     = 64,
   localparam int unsigned COLS = LINE_BITS / HOST_W,
   localparam int unsigned XW   = $clog2(COLS),
   localparam int unsigned YW   = $clog2(LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_set_x,
   input  logic                 cmd_set_y,
   input  logic                 cmd_set_ctl,
   input  logic                 rd_stb,
   input  logic                 wr_stb,
   input  logic [HOST_W-1:0]    host_din,
   output logic [HOST_W-1:0]    host_dout,
   output logic                 host_dout_vld,
   input  logic [YW-1:0]        scan_line,
   output logic [LINE_BITS-1:0] scan_data
);
   logic [XW-1:0] cur_x;
   logic [YW-1:0] cur_y;

   dram_addr_ctl #(.COLS(COLS), .LINES(LINES)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_x   (cmd_set_x),
      .set_y   (cmd_set_y),
      .set_ctl (cmd_set_ctl),
      .access  (rd_stb | wr_stb),
      .din     (host_din),
      .x_o     (cur_x),
      .y_o     (cur_y)
   );

   dram_store #(.LINE_BITS(LINE_BITS), .LINES(LINES)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (wr_stb),
      .rd        (rd_stb),
      .x         (cur_x),
      .y         (cur_y),
      .din       (host_din),
      .scan_line (scan_line),
      .dout      (host_dout),
      .dout_vld  (host_dout_vld),
      .scan_data (scan_data)
   );

   // R10: host strobes are mutually exclusive
   a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_set_x, cmd_set_y, cmd_set_ctl, rd_stb, wr_stb}));
endmodule

// File: tb/dram_host_port_tb.sv
module dram_host_port_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 200000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cmd_set_x = 0, cmd_set_y = 0, cmd_set_ctl = 0, rd_stb = 0, wr_stb = 0;
   logic [7:0]   host_din = '0;
   logic [7:0]   host_dout;
   logic         host_dout_vld;
   logic [5:0]   scan_line = '0;
   logic [127:0] scan_data;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   bit scan_en = 0;

   logic [7:0] m_mem [64][16];
   int mx = 0, my = 0;
   bit sx = 0, sy = 0;

   dram_host_port u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_set_x(cmd_set_x), .cmd_set_y(cmd_set_y),
      .cmd_set_ctl(cmd_set_ctl), .rd_stb(rd_stb), .wr_stb(wr_stb),
      .host_din(host_din), .host_dout(host_dout), .host_dout_vld(host_dout_vld),
      .scan_line(scan_line), .scan_data(scan_data)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(string tag, logic [127:0] got, logic [127:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic logic [127:0] model_line(int l);
      logic [127:0] v;
      for (int c = 0; c < 16; c++) v[c*8 +: 8] = m_mem[l][c];
      return v;
   endfunction

   function automatic void model_step();
      if (sx) mx = (mx + 1) % 16;
      if (sy) my = (my + 1) % 64;
   endfunction

   // kind: 0 set_x, 1 set_y, 2 set_ctl, 3 write, 4 read, 5 idle
   task automatic do_op(int kind, logic [7:0] v, logic [5:0] sl, string tag);
      logic [7:0] exp_rd;
      bit hit;
      exp_rd = 8'h00;
      hit = (kind == 3) && (int'(sl) == my);
      host_din = v;
      scan_line = sl;
      cmd_set_x = (kind == 0);
      cmd_set_y = (kind == 1);
      cmd_set_ctl = (kind == 2);
      wr_stb = (kind == 3);
      rd_stb = (kind == 4);
      case (kind)
         0: if (v < 16) mx = v;
         1: my = v % 64;
         2: begin sx = v[0]; sy = v[1]; end
         3: begin m_mem[my][mx] = v; model_step(); end
         4: begin exp_rd = m_mem[my][mx]; model_step(); end
         default: ;
      endcase
      @(negedge clk);
      {cmd_set_x, cmd_set_y, cmd_set_ctl, wr_stb, rd_stb} = '0;
      if (kind == 4) begin
         chk({tag, " R7 read valid"}, {127'd0, host_dout_vld}, 128'd1);
         chk({tag, " R8 read data"}, {120'd0, host_dout}, {120'd0, exp_rd});
      end else begin
         chk({tag, " R7 valid low"}, {127'd0, host_dout_vld}, 128'd0);
      end
      if (scan_en)
         chk(hit ? {tag, " R9 scan bypass"} : {tag, " R1 scan line"},
             scan_data, model_line(sl));
   endtask

   initial begin
      int cyc;
      cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > WATCHDOG && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired got %0d expected %0d", cyc, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      logic [7:0] rv;
      int k;
      void'($urandom(32'd1234));
      for (int l = 0; l < 64; l++)
         for (int c = 0; c < 16; c++) m_mem[l][c] = 8'h00;
      repeat (3) @(negedge clk);
      // reset state: R4 and R7
      chk("R7 reset valid", {127'd0, host_dout_vld}, 128'd0);
      chk("R7 reset data", {120'd0, host_dout}, 128'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4: steps disabled after reset; write then read hits line 0 column 0
      do_op(3, 8'hC3, 6'd0, "R4 reset ptr");
      do_op(4, 8'h00, 6'd0, "R4 no step");
      do_op(4, 8'h00, 6'd0, "R4 no step again");

      // fill memory with X stepping (R1, R6 x wrap inside the line)
      do_op(2, 8'h01, 6'd0, "R4 ctl");
      for (int l = 0; l < 64; l++) begin
         do_op(1, 8'(l), 6'd0, "R3 set y");
         do_op(0, 8'h00, 6'd0, "R2 set x");
         for (int c = 0; c < 16; c++) do_op(3, 8'($urandom), 6'(l), "R8 fill");
      end
      scan_en = 1;
      for (int l = 0; l < 64; l++) do_op(5, 8'h00, 6'(l), "R1 scan");

      // R2: refused column values
      do_op(0, 8'h05, 6'd0, "R2 set x 5");
      do_op(0, 8'h10, 6'd0, "R2 refuse 16");
      do_op(0, 8'hFF, 6'd0, "R2 refuse 255");
      do_op(2, 8'h00, 6'd0, "R4 steps off");
      do_op(1, 8'h07, 6'd7, "R3 set y 7");
      do_op(3, 8'hA5, 6'd7, "R2 write at x5");
      do_op(4, 8'h00, 6'd7, "R2 read at x5");

      // R3: only low six bits used
      do_op(1, 8'hC9, 6'd9, "R3 high bits");
      do_op(4, 8'h00, 6'd9, "R3 read line 9");

      // R6: X wrap and Y wrap; R5 both step
      do_op(2, 8'h01, 6'd0, "R5 x only");
      do_op(0, 8'h0F, 6'd0, "R6 x 15");
      do_op(4, 8'h00, 6'd9, "R6 read x15");
      do_op(4, 8'h00, 6'd9, "R6 read x0");
      do_op(2, 8'h02, 6'd0, "R5 y only");
      do_op(1, 8'h3F, 6'd63, "R6 y 63");
      do_op(3, 8'h3C, 6'd63, "R6 write y63");
      do_op(3, 8'h4B, 6'd0, "R6 write y0");
      do_op(2, 8'h03, 6'd0, "R5 both");
      do_op(4, 8'h00, 6'd1, "R5 read both");
      do_op(4, 8'h00, 6'd2, "R5 read both 2");
      // R5: commands and idle never step
      do_op(5, 8'h00, 6'd0, "R5 idle");
      do_op(2, 8'h03, 6'd0, "R5 ctl again");
      do_op(4, 8'h00, 6'd3, "R5 after cmds");

      // R9: same-cycle bypass
      do_op(1, 8'h14, 6'd20, "R9 set y");
      do_op(3, 8'h99, 6'd20, "R9 write hit");

      // random mix, R10 respected by construction
      for (int n = 0; n < 4000; n++) begin
         k = int'($urandom % 10);
         rv = 8'($urandom);
         case (k)
            0: do_op(0, (rv[7] ? rv : {4'h0, rv[3:0]}), 6'($urandom), "R2 rnd");
            1: do_op(1, rv, 6'($urandom), "R3 rnd");
            2: do_op(2, rv, 6'($urandom), "R4 rnd");
            3, 4, 5: do_op(3, rv, ($urandom % 2) ? 6'(my) : 6'($urandom), "R8 rnd");
            6, 7, 8: do_op(4, rv, 6'($urandom), "R5 rnd");
            default: do_op(5, rv, 6'($urandom), "R1 rnd");
         endcase
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule